// File: doc/BRIEF.md
# Configurable GPIO Port with Grouped Interrupt

This block is one general-purpose I/O port of a small microcontroller. Each pin is set on its own through three per-bit registers: the direction bit picks input or output, the data latch holds the level an output drives, and the option bit turns an input into an interrupt source. Pins reach the block as separate input, output and output-enable vectors. A simple register bus lets software read and write the port. A read of the data register returns the pad level for input bits and the latch for output bits.

Every input whose option bit is set belongs to the port's interrupt group. The group is merged into one request. The NAND of the enabled pins goes high while any of them is low. The edge and level logic work on its complement, called the group line, which is high only when every enabled pin is high. So a pin held low keeps the line low and hides activity on the other pins. A 2-bit sensitivity field in the control register picks level or edge behaviour. Edge events are held in a pending flag that software clears by writing one.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the data, direction, option and sensitivity fields are zero, pad_oe_o and pad_out_o are zero, irq_o is low, and reads of addresses 1, 2 and 3 return zero.
- R2: Register map: address 0 is the data register, 1 the direction register, 2 the option register, and 3 control. In control, bits [1:0] are the sensitivity and bit 2 is the pending flag.
- R3: A direction bit of 1 makes its pin an output. pad_oe_o follows the direction register from the cycle after the write.
- R4: For input bits, a read of address 0 returns the pad level after a two-flop synchronizer, so a pad change is visible two clock edges later. For output bits it returns the data latch.
- R5: A write to address 0 updates the latch on pad_out_o in the next cycle and leaves pad_oe_o unchanged, so an input pin stays undriven.
- R6: When a pin turns from input to output, it drives the value already in its latch in the same cycle that its pad_oe_o bit rises.
- R7: Only pins with option=1 and direction=0 join the interrupt group. Toggling other pins never raises irq_o.
- R8: The group line is the AND of the enabled synchronized pins, which is the complement of their NAND. One enabled pin held low hides any edge on the other enabled pins.
- R9: Sensitivity 01 sets pending on a rising edge of the line, 10 on a falling edge, and 11 on either edge. In these modes irq_o equals the pending flag, seen one cycle after the synchronized line changes.
- R10: Sensitivity 00 is level mode. irq_o is high exactly while the group line is low, and it is not held after the line returns high.
- R11: Writing address 3 with bit 2 set clears the pending flag, and irq_o then drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data for bus_addr_i (combinational) |
| pad_in_i | input | WIDTH | Pad input levels (asynchronous) |
| pad_out_o | output | WIDTH | Output latch value to the pads |
| pad_oe_o | output | WIDTH | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt request of the group |

## Verification
Assertions check on every cycle how register writes reach pad_oe_o and pad_out_o: a data write never disturbs the enables. They also check that a rising line in rising-edge mode always leaves the flag pending, that a clear with no edge leaves it empty, and that irq_o is low in edge modes without a pending event. Only the bench scenarios can show the masking effect of a pin held low, the exclusion of output and non-option pins, the two-cycle synchronizer delay on reads, and the difference between held edge requests and the non-latching level mode.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] A_OPT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;
    localparam int CTRL_PEND_BIT = 2;

    typedef enum logic [1:0] {
        SENS_LOW  = 2'b00,
        SENS_RISE = 2'b01,
        SENS_FALL = 2'b10,
        SENS_BOTH = 2'b11
    } sens_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.st[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.st[i] = s_q.st[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.st[STAGES-1];
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_s_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [1:0]       sens_i,
    input  logic             clr_i,
    output logic             line_o,
    output logic             pending_o,
    output logic             irq_o
);
    typedef struct packed {
        logic line_prev;
        logic pending;
    } grp_t;

    grp_t g_d, g_q;
    logic rise, fall, hit;

    always_comb begin
        // disabled pins read as high so they never pull the line
        line_o = &(pin_s_i | ~en_i);
        rise   = line_o & ~g_q.line_prev;
        fall   = ~line_o & g_q.line_prev;
        unique case (sens_e'(sens_i))
            SENS_RISE: hit = rise;
            SENS_FALL: hit = fall;
            SENS_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        g_d = g_q;
        g_d.line_prev = line_o;
        if (hit)        g_d.pending = 1'b1;
        else if (clr_i) g_d.pending = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '{line_prev: 1'b1, pending: 1'b0};
        else         g_q <= g_d;
    end

    assign pending_o = g_q.pending;
    assign irq_o     = (sens_e'(sens_i) == SENS_LOW) ? ~line_o : g_q.pending;

    // R9
    rise_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sens_i == 2'b01) && $rose(line_o) |=> pending_o);

    // R11
    clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i && $stable(line_o) |=> !pending_o);

    // R9
    edge_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sens_i != 2'b00) && !pending_o |-> !irq_o);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_we_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  pad_in_i,
    output logic [WIDTH-1:0]  pad_out_o,
    output logic [WIDTH-1:0]  pad_oe_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] opt;
        logic [1:0]       sens;
    } port_t;

    port_t r_d, r_q;
    logic [WIDTH-1:0] pin_s;
    logic             clr, line, pending;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_in_i),
        .q_o    (pin_s)
    );

    gpio_irq_group #(.WIDTH(WIDTH)) u_grp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_s_i   (pin_s),
        .en_i      (r_q.opt & ~r_q.dir),
        .sens_i    (r_q.sens),
        .clr_i     (clr),
        .line_o    (line),
        .pending_o (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        r_d = r_q;
        clr = 1'b0;
        if (bus_we_i) begin
            unique case (bus_addr_i)
                A_DATA: r_d.data = bus_wdata_i;
                A_DIR:  r_d.dir  = bus_wdata_i;
                A_OPT:  r_d.opt  = bus_wdata_i;
                default: begin
                    r_d.sens = bus_wdata_i[1:0];
                    clr      = bus_wdata_i[CTRL_PEND_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            A_DATA: bus_rdata_o = (r_q.dir & r_q.data) | (~r_q.dir & pin_s);
            A_DIR:  bus_rdata_o = r_q.dir;
            A_OPT:  bus_rdata_o = r_q.opt;
            default: begin
                bus_rdata_o[1:0]           = r_q.sens;
                bus_rdata_o[CTRL_PEND_BIT] = pending;
            end
        endcase
    end

    assign pad_out_o = r_q.data;
    assign pad_oe_o  = r_q.dir;

    // R3
    dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_we_i && (bus_addr_i == A_DIR) |=> pad_oe_o == $past(bus_wdata_i));

    // R5
    data_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_we_i && (bus_addr_i == A_DATA)
        |=> $stable(pad_oe_o) && (pad_out_o == $past(bus_wdata_i)));

    // R10
    level_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.sens == 2'b00) && line |-> !irq_o);
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   addr = '0;
    logic         we = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pins = '0;
    logic [W-1:0] pout, poe;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.WIDTH(W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pins),
        .pad_out_o(pout), .pad_oe_o(poe), .irq_o(irq)
    );

    function automatic logic [W-1:0] exp_rd(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] p);
        return (d & l) | (~d & p);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] v);
        @(negedge clk);
        addr = a; wdata = v; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    // pins change at a negedge; three edges cover sync plus pending
    task automatic set_pins(logic [W-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] d, l, p;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", poe, 0);
        chk("R1 out", pout, 0);
        chk("R1 irq", irq, 0);
        rd(2'd1, v); chk("R1 dir", v, 0);
        rd(2'd2, v); chk("R1 opt", v, 0);
        rd(2'd3, v); chk("R1 ctrl", v, 0);

        // R5 latch write in input mode, R6 switch to output
        wr(2'd0, 8'h5A);
        chk("R5 out", pout, 8'h5A);
        chk("R5 oe", poe, 0);
        @(negedge clk); addr = 2'd1; wdata = 8'hF0; we = 1'b1;
        @(posedge clk); #1;
        chk("R6 oe", poe, 8'hF0);
        chk("R6 out", pout, 8'h5A);
        @(negedge clk); we = 1'b0;
        chk("R3 dir", poe, 8'hF0);

        // R4 sync delay on reads
        @(negedge clk); pins = 8'h3C; addr = 2'd0;
        @(posedge clk); @(negedge clk); #1;
        chk("R4 one edge", rdata, exp_rd(8'hF0, 8'h5A, 8'h00));
        @(posedge clk); @(negedge clk); #1;
        chk("R4 two edges", rdata, exp_rd(8'hF0, 8'h5A, 8'h3C));

        // R2 R3 R4 R5 random register and pad traffic
        for (int i = 0; i < 40; i++) begin
            d = 8'($urandom); l = 8'($urandom); p = 8'($urandom);
            wr(2'd1, d);
            wr(2'd0, l);
            set_pins(p);
            chk("R3 rand oe", poe, d);
            chk("R5 rand out", pout, l);
            rd(2'd0, v); chk("R4 rand read", v, exp_rd(d, l, p));
            rd(2'd1, v); chk("R2 dir read", v, d);
        end

        // interrupt setup: all inputs, pins high, falling mode
        wr(2'd1, 8'h00);
        set_pins(8'hFF);
        wr(2'd3, 8'h06);
        wr(2'd2, 8'h03);
        chk("R9 no event", irq, 0);
        rd(2'd2, v); chk("R2 opt read", v, 8'h03);

        // R9 falling sets pending
        set_pins(8'hFE);
        chk("R9 fall", irq, 1);
        rd(2'd3, v); chk("R2 ctrl pend", v, 8'h06);
        // R11 clear
        wr(2'd3, 8'h06);
        chk("R11 clear", irq, 0);
        // R9 rising ignored in falling mode
        set_pins(8'hFF);
        chk("R9 rise ignored", irq, 0);

        // R7 non-option pin and output pin ignored
        set_pins(8'hFB);
        chk("R7 no option", irq, 0);
        wr(2'd1, 8'h02);
        wr(2'd3, 8'h06);
        set_pins(8'hFD);
        chk("R7 output pin", irq, 0);
        wr(2'd1, 8'h00);
        set_pins(8'hFF);
        wr(2'd3, 8'h06);

        // R8 masking: pin1 low, then pin0 toggles unseen
        set_pins(8'hFD);
        chk("R8 first low", irq, 1);
        wr(2'd3, 8'h06);
        set_pins(8'hFC);
        chk("R8 masked fall", irq, 0);
        set_pins(8'hFD);
        chk("R8 masked rise", irq, 0);

        // R9 rising mode
        wr(2'd3, 8'h05);
        chk("R11 clear rise mode", irq, 0);
        set_pins(8'hFF);
        chk("R9 rise", irq, 1);
        wr(2'd3, 8'h05);
        set_pins(8'hFE);
        chk("R9 fall ignored", irq, 0);

        // R9 both edges
        wr(2'd3, 8'h07);
        set_pins(8'hFF);
        chk("R9 both rise", irq, 1);
        wr(2'd3, 8'h07);
        chk("R11 both clear", irq, 0);
        set_pins(8'hFE);
        chk("R9 both fall", irq, 1);

        // R10 level mode
        wr(2'd3, 8'h04);
        chk("R10 low level", irq, 1);
        set_pins(8'hFF);
        chk("R10 released", irq, 0);
        set_pins(8'hFD);
        chk("R10 pin1 low", irq, 1);
        set_pins(8'hFF);
        chk("R10 not held", irq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule